// File: doc/BRIEF.md
# Flash Program/Erase Fault Guard

This block sits between the CPU register bus and a flash array. It holds the mode control bits and the block-select bits, and it drives one mode strobe to the array. The mode is program, erase, program-verify or erase-verify. It also watches a set of single-cycle CPU-side events. Any of these events can show that software has run away while the array is being programmed or erased.

If such an event arrives while a program or erase strobe is live, a sticky fault flag is latched. The live strobe falls in the same cycle the flag rises, and a one-cycle abort pulse is issued. The register contents stay as they were. While the flag is set, the program and erase strobes stay blocked no matter what software writes. The verify strobes can still be raised. Only the reset input or the hardware standby level clears the flag.

Top module: `flash_guard`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `hw_stby` high, the fault flag is 0. All four strobes are 0, and every register reads back 0.
- R2: Register map. Address 0 is the mode register: bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify. Address 1 bit0 is the read-only fault flag. Addresses 2 and up are block-select registers. `rd_data` shows the register at `rd_addr` in the same cycle, and a write takes effect at the next rising edge.
- R3: At most one strobe is high at a time, with priority program > erase > program-verify > erase-verify. The erase strobe needs at least one block-select bit set.
- R4: A flash read event (`ev_flash_rd`) while the program or erase strobe is high sets the fault flag at the next edge.
- R5: An exception-entry event sets the flag under the same condition, unless `ev_exc_rst` marks it as a reset.
- R6: A sleep/standby-entry event or a bus-loss event sets the flag under the same condition.
- R7: Events arriving while no program or erase strobe is high, including while a verify strobe is high, leave the flag at 0.
- R8: In the cycle the flag rises, the program and erase strobes are 0. The mode and block-select registers keep their contents.
- R9: While the flag is 1, writing the program or erase bits again raises neither strobe.
- R10: While the flag is 1, setting a verify bit raises the matching verify strobe.
- R11: Once set, the flag stays 1 until reset or `hw_stby`. Writes to address 1 have no effect.
- R12: `abort` is high for exactly one cycle: the first cycle in which the flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby level; holds all state at reset values |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| ev_flash_rd | input | 1 | CPU read of the flash array this cycle |
| ev_exc | input | 1 | Exception handling begins this cycle |
| ev_exc_rst | input | 1 | The exception in `ev_exc` is a reset |
| ev_sleep | input | 1 | Sleep or software standby entry this cycle |
| ev_bus_loss | input | 1 | CPU gives up the bus this cycle |
| fault | output | 1 | Sticky fault flag |
| strb_prog | output | 1 | Program strobe to array |
| strb_erase | output | 1 | Erase strobe to array |
| strb_pver | output | 1 | Program-verify strobe to array |
| strb_ever | output | 1 | Erase-verify strobe to array |
| abort | output | 1 | One-cycle abort pulse |

## Verification
The bench builds the block with its default values: 8-bit registers and two block-select registers, which gives a 2-bit address. Every address is reachable with these values, including the upper block-select register and the read-only flag slot. This means the erase-enable condition can be met from either block register, and an ignored write to the flag can be tried. Each of the four fault causes is applied both with a program or erase strobe live and with only a verify strobe live.

// File: rtl/fg_pkg.sv
package fg_pkg;

    // Mode register layout; bit positions are decoded by the strobe selector
    typedef struct packed {
        logic ever;
        logic pver;
        logic erase;
        logic prog;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // Fault-cause vector ordering used by the fault tracker
    typedef struct packed {
        logic bus_loss;
        logic sleep;
        logic exc;
        logic flash_rd;
    } cause_t;

endpackage

// File: rtl/fg_regs.sv
module fg_regs #(
    parameter int DATA_W = 8,
    parameter int NBSEL  = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fault_q,
    output fg_pkg::mode_t     mode_o,
    output logic              bsel_any,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MODE_W  = fg_pkg::MODE_W;
    localparam int BSEL_LO = 2;

    typedef struct packed {
        fg_pkg::mode_t                     mode;
        logic [NBSEL-1:0][DATA_W-1:0]      bsel;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) begin
                regs_d.mode = fg_pkg::mode_t'(wr_data[MODE_W-1:0]);
            end
            for (int i = 0; i < NBSEL; i++) begin
                if (wr_addr == ADDR_W'(i + BSEL_LO)) begin
                    regs_d.bsel[i] = wr_data;
                end
            end
        end
        if (hw_stby) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(0)) begin
            rd_data[MODE_W-1:0] = regs_q.mode;
        end
        if (rd_addr == ADDR_W'(1)) begin
            rd_data[0] = fault_q;
        end
        for (int i = 0; i < NBSEL; i++) begin
            if (rd_addr == ADDR_W'(i + BSEL_LO)) begin
                rd_data = regs_q.bsel[i];
            end
        end
    end

    assign mode_o   = regs_q.mode;
    assign bsel_any = |regs_q.bsel;

endmodule

// File: rtl/fg_sel.sv
module fg_sel (
    input  fg_pkg::mode_t mode,
    input  logic          bsel_any,
    input  logic          fault_q,
    output fg_pkg::mode_t strobe
);
    logic want_prog, want_erase;

    always_comb begin
        want_prog  = mode.prog & ~fault_q;
        want_erase = mode.erase & bsel_any & ~fault_q;
        strobe     = '0;
        if (want_prog) begin
            strobe.prog = 1'b1;
        end else if (want_erase) begin
            strobe.erase = 1'b1;
        end else if (mode.pver) begin
            strobe.pver = 1'b1;
        end else if (mode.ever) begin
            strobe.ever = 1'b1;
        end
    end

endmodule

// File: rtl/fg_fault.sv
module fg_fault (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hw_stby,
    input  logic           pe_live,
    input  fg_pkg::cause_t cause,
    input  logic           exc_is_rst,
    output logic           fault_q,
    output logic           abort_q
);
    typedef struct packed {
        logic fault;
        logic abort;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        hit = pe_live & (cause.flash_rd | (cause.exc & ~exc_is_rst)
                         | cause.sleep | cause.bus_loss);
        st_d       = st_q;
        st_d.abort = 1'b0;
        if (hit && !st_q.fault) begin
            st_d.fault = 1'b1;
            st_d.abort = 1'b1;
        end
        if (hw_stby) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_q = st_q.fault;
    assign abort_q = st_q.abort;

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter  int DATA_W = 8,
    parameter  int NBSEL  = 2,
    localparam int ADDR_W = $clog2(NBSEL + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_flash_rd,
    input  logic              ev_exc,
    input  logic              ev_exc_rst,
    input  logic              ev_sleep,
    input  logic              ev_bus_loss,
    output logic              fault,
    output logic              strb_prog,
    output logic              strb_erase,
    output logic              strb_pver,
    output logic              strb_ever,
    output logic              abort
);
    fg_pkg::mode_t  mode, strobe;
    fg_pkg::cause_t cause;
    logic           bsel_any;
    logic           fault_q, abort_q;

    assign cause = '{bus_loss: ev_bus_loss, sleep: ev_sleep,
                     exc: ev_exc, flash_rd: ev_flash_rd};

    fg_regs #(.DATA_W(DATA_W), .NBSEL(NBSEL), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .fault_q(fault_q),
        .mode_o(mode), .bsel_any(bsel_any), .rd_data(rd_data)
    );

    fg_sel u_sel (
        .mode(mode), .bsel_any(bsel_any), .fault_q(fault_q), .strobe(strobe)
    );

    fg_fault u_fault (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
        .pe_live(strobe.prog | strobe.erase),
        .cause(cause), .exc_is_rst(ev_exc_rst),
        .fault_q(fault_q), .abort_q(abort_q)
    );

    assign fault      = fault_q;
    assign abort      = abort_q;
    assign strb_prog  = strobe.prog;
    assign strb_erase = strobe.erase;
    assign strb_pver  = strobe.pver;
    assign strb_ever  = strobe.ever;

endmodule

// File: rtl/fg_chk.sv
module fg_chk (
    input logic clk,
    input logic rst_n,
    input logic hw_stby,
    input logic ev_flash_rd,
    input logic ev_exc,
    input logic ev_exc_rst,
    input logic ev_sleep,
    input logic ev_bus_loss,
    input logic fault,
    input logic abort,
    input logic strb_prog,
    input logic strb_erase,
    input logic strb_pver,
    input logic strb_ever,
    input logic bsel_any
);
    logic any_ev;
    assign any_ev = ev_flash_rd | (ev_exc & ~ev_exc_rst) | ev_sleep | ev_bus_loss;

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strb_prog, strb_erase, strb_pver, strb_ever}));

    p_erase_needs_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strb_erase |-> bsel_any);

    p_standby_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (!fault && !strb_prog && !strb_erase && !strb_pver && !strb_ever));

    p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(strb_prog || strb_erase) && $past(any_ev)));

    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!strb_prog && !strb_erase));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !hw_stby) |=> fault);

    p_abort_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $rose(fault));

    p_rise_gives_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> abort);

    p_abort_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

endmodule

bind flash_guard fg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
    .ev_flash_rd(ev_flash_rd), .ev_exc(ev_exc), .ev_exc_rst(ev_exc_rst),
    .ev_sleep(ev_sleep), .ev_bus_loss(ev_bus_loss),
    .fault(fault), .abort(abort),
    .strb_prog(strb_prog), .strb_erase(strb_erase),
    .strb_pver(strb_pver), .strb_ever(strb_ever),
    .bsel_any(bsel_any)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
    localparam int NROW = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ev_flash_rd = 1'b0, ev_exc = 1'b0, ev_exc_rst = 1'b0;
    logic       ev_sleep = 1'b0, ev_bus_loss = 1'b0;
    logic       fault, strb_prog, strb_erase, strb_pver, strb_ever, abort;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_flash_rd(ev_flash_rd), .ev_exc(ev_exc), .ev_exc_rst(ev_exc_rst),
        .ev_sleep(ev_sleep), .ev_bus_loss(ev_bus_loss),
        .fault(fault), .strb_prog(strb_prog), .strb_erase(strb_erase),
        .strb_pver(strb_pver), .strb_ever(strb_ever), .abort(abort)
    );

    // row: hw(1) we(1) addr(2) data(8) ev{bus,sleep,excrst,exc,rd}(5)
    //      exp strobes{ever,pver,erase,prog}(4) exp fault(1) exp abort(1)
    localparam logic [22:0] TBL [NROW] = '{
        {1'b0,1'b1,2'd0,8'h01,5'b00000,4'b0001,1'b0,1'b0}, // 0  R2 program bit
        {1'b0,1'b0,2'd0,8'h00,5'b00001,4'b0000,1'b1,1'b1}, // 1  R4 read during program
        {1'b0,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b1,1'b0}, // 2  R12 pulse ends
        {1'b0,1'b1,2'd0,8'h01,5'b00000,4'b0000,1'b1,1'b0}, // 3  R9 re-write program
        {1'b0,1'b1,2'd0,8'h05,5'b00000,4'b0100,1'b1,1'b0}, // 4  R10 verify under fault
        {1'b0,1'b1,2'd1,8'h00,5'b00000,4'b0100,1'b1,1'b0}, // 5  R11 flag write ignored
        {1'b1,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 6  R1 standby
        {1'b0,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 7  R1 after standby
        {1'b0,1'b1,2'd0,8'h02,5'b00000,4'b0000,1'b0,1'b0}, // 8  R3 erase w/o block
        {1'b0,1'b1,2'd2,8'h01,5'b00000,4'b0010,1'b0,1'b0}, // 9  R3 erase with block
        {1'b0,1'b0,2'd0,8'h00,5'b00110,4'b0010,1'b0,1'b0}, // 10 R5 reset exception
        {1'b0,1'b0,2'd0,8'h00,5'b00010,4'b0000,1'b1,1'b1}, // 11 R5 other exception
        {1'b1,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 12 R1 standby
        {1'b0,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 13 R1 release
        {1'b0,1'b1,2'd0,8'h04,5'b00000,4'b0100,1'b0,1'b0}, // 14 R2 pver bit
        {1'b0,1'b0,2'd0,8'h00,5'b11011,4'b0100,1'b0,1'b0}, // 15 R7 events in verify
        {1'b0,1'b1,2'd0,8'h0F,5'b00000,4'b0001,1'b0,1'b0}, // 16 R3 priority
        {1'b0,1'b0,2'd0,8'h00,5'b01000,4'b0100,1'b1,1'b1}, // 17 R6 sleep, R10
        {1'b1,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 18 R1 standby
        {1'b0,1'b0,2'd0,8'h00,5'b00000,4'b0000,1'b0,1'b0}, // 19 R1 release
        {1'b0,1'b1,2'd3,8'h80,5'b00000,4'b0000,1'b0,1'b0}, // 20 R2 upper block reg
        {1'b0,1'b1,2'd0,8'h0A,5'b00000,4'b0010,1'b0,1'b0}, // 21 R3 erase beats ever
        {1'b0,1'b0,2'd0,8'h00,5'b10000,4'b1000,1'b1,1'b1}, // 22 R6 bus loss, R8
        {1'b0,1'b0,2'd0,8'h00,5'b00000,4'b1000,1'b1,1'b0}  // 23 R12
    };

    function automatic string row_tag(int r);
        case (r)
            1: return "R4";
            2, 23: return "R12";
            3: return "R9";
            4: return "R10";
            5: return "R11";
            6, 7, 12, 13, 18, 19: return "R1";
            8, 9, 16, 21: return "R3";
            10, 11: return "R5";
            15: return "R7";
            17, 22: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hw_stby = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ev_flash_rd = 1'b0; ev_exc = 1'b0; ev_exc_rst = 1'b0;
        ev_sleep = 1'b0; ev_bus_loss = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    function automatic logic [3:0] strobes();
        return {strb_ever, strb_pver, strb_erase, strb_prog};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #2;
        // R1 reset state
        chk("R1 fault", 32'(fault), 32'd0);
        chk("R1 strobes", 32'(strobes()), 32'd0);
        rd_addr = 2'd0; #1;
        chk("R1 mode readback", 32'(rd_data), 32'd0);

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            {hw_stby, wr_en, wr_addr, wr_data,
             ev_bus_loss, ev_sleep, ev_exc_rst, ev_exc, ev_flash_rd} = TBL[r][22:6];
            step();
            chk($sformatf("%s row %0d strobes", row_tag(r), r), 32'(strobes()), 32'(TBL[r][5:2]));
            chk($sformatf("%s row %0d fault", row_tag(r), r), 32'(fault), 32'(TBL[r][1]));
            chk($sformatf("%s row %0d abort", row_tag(r), r), 32'(abort), 32'(TBL[r][0]));
        end

        // R8: registers retained when the fault fires; R2 readback
        do_reset();
        wr(2'd2, 8'h5A);
        wr(2'd3, 8'hC3);
        wr(2'd0, 8'h03);
        chk("R3 program wins over erase", 32'(strobes()), 32'h1);
        @(negedge clk);
        idle_inputs();
        ev_flash_rd = 1'b1;
        ev_sleep = 1'b1;
        step();
        chk("R8 strobes drop with flag", 32'(strobes()), 32'h0);
        chk("R8 flag set", 32'(fault), 32'd1);
        @(negedge clk);
        idle_inputs();
        rd_addr = 2'd0; #1;
        chk("R8 mode kept", 32'(rd_data), 32'h03);
        rd_addr = 2'd2; #1;
        chk("R8 block reg kept", 32'(rd_data), 32'h5A);
        rd_addr = 2'd3; #1;
        chk("R8 upper block reg kept", 32'(rd_data), 32'hC3);
        rd_addr = 2'd1; #1;
        chk("R2 flag readback", 32'(rd_data), 32'h01);

        // R11: flag write ignored, many idle cycles keep it
        wr(2'd1, 8'h00);
        for (int i = 0; i < 5; i++) step();
        chk("R11 flag held", 32'(fault), 32'd1);

        // R12: event held two cycles gives one pulse
        do_reset();
        wr(2'd0, 8'h01);
        @(negedge clk);
        idle_inputs();
        ev_bus_loss = 1'b1;
        step();
        chk("R12 pulse high", 32'(abort), 32'd1);
        step();
        chk("R12 pulse once", 32'(abort), 32'd0);

        // R1: reset input clears a set flag and registers
        do_reset();
        #2;
        chk("R1 flag after reset", 32'(fault), 32'd0);
        rd_addr = 2'd2; #1;
        chk("R1 block reg after reset", 32'(rd_data), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule